// File: doc/BRIEF.md
# Bus Cycle Terminator with Pseudo-DMA Handshake

This block ends bus cycles on an asynchronous 68000-style bus. It watches the address strobe and a set of region-select inputs that an external decoder supplies. It drives the data-acknowledge line as an open-drain style enable, so the pad either pulls the line low or floats it. It drives the bus-error line for accesses that stall. For SCSI accesses it also drives the SCSI controller's chip select. A pseudo-DMA handshake can replace the usual fixed-delay acknowledge. In that case the chip select is dropped and the block waits for the controller's data request. It then acknowledges the CPU and the controller together and stretches the DMA-acknowledge strobe to a guaranteed minimum width.

An expansion card can claim a cycle by pulling its external-acknowledge input low. While that input is low, the block's own acknowledge driver is turned off. The block's own acknowledge always waits a set number of cycles, which gives the card time to respond first. A long watchdog times out expansion and SCSI accesses. Plain memory accesses and accesses to unmapped space never raise bus error.

All inputs are assumed synchronous to `clk`. The acknowledge delay, the DMA-acknowledge width and the watchdog limit are parameters counted in clock cycles. The default watchdog is about 265 ms at a 15.67 MHz clock.

Top module: `bus_cycle_term`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is released by that edge: `dtack_oe`=0, `berr_n`=1, `dack_n`=1, `scsi_cs_n`=1.
- R2: Call the rising edge at which the block first samples `as_n` low (while idle and with no DMA-acknowledge pulse running) the start edge. For a RAM, expansion or plain SCSI access, `dtack_oe` goes to 1 exactly `ACK_DLY` edges after the start edge, and not before.
- R3: For a plain SCSI access (`sel_scsi`=1, `sel_pdma`=0), `scsi_cs_n` goes low at the start edge and stays low until strobe release.
- R4: For a pseudo-DMA access (`sel_scsi`=1, `sel_pdma`=1), `scsi_cs_n` goes low at the start edge and returns high `ACK_DLY` edges later. `dtack_oe` then stays 0 for as long as `drq` is low.
- R5: In a pseudo-DMA access, the edge after `scsi_cs_n` has been released that samples `drq`=1 sets `dtack_oe`=1 and `dack_n`=0 together. `dack_n` then stays low for exactly `DACK_W` cycles, whatever the strobe does.
- R6: `dack_n` and `scsi_cs_n` are never low at the same time. A new access is not started while a DMA-acknowledge pulse is running.
- R7: While `ext_ack_n` is low, `dtack_oe` is 0 in the same cycle. When `ext_ack_n` rises again during an acknowledged access, `dtack_oe` returns to 1 in the same cycle.
- R8: In an expansion or SCSI access, if `as_n` is still low `TMO_CYC` edges after the start edge, `berr_n` goes low at that edge. It stays low until strobe release.
- R9: A RAM access (`sel_ram`=1) never drives `berr_n` low, however long the strobe is held.
- R10: At the first edge that samples `as_n` high during an access, `dtack_oe`, `berr_n` and `scsi_cs_n` are released. The delay and watchdog counts restart from zero with the next access.
- R11: An access with no region selected is never acknowledged by the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| sel_ram | input | 1 | Decoded select: memory region (lowest priority) |
| sel_exp | input | 1 | Decoded select: expansion slot region |
| sel_scsi | input | 1 | Decoded select: SCSI controller region (highest priority) |
| sel_pdma | input | 1 | With `sel_scsi`, marks the access as pseudo-DMA |
| drq | input | 1 | Data request from the SCSI controller, active high |
| ext_ack_n | input | 1 | Acknowledge claimed by an expansion card, active low |
| dtack_oe | output | 1 | 1: pad pulls data-acknowledge low; 0: pad floats |
| berr_n | output | 1 | Bus error, active low |
| dack_n | output | 1 | DMA acknowledge to the SCSI controller, active low |
| scsi_cs_n | output | 1 | SCSI controller chip select, active low |

## Verification
The assertions take four things for granted about the inputs. They change only between rising edges. At most one of the region selects is high. The selects and `sel_pdma` stay steady while the strobe is low. `sel_pdma` is only set together with `sel_scsi`. The stimulus drives every input a moment after a rising edge and sets the selects together with the falling strobe. It clears them only when the strobe rises, and it never raises two selects in the same access. It also raises `drq` only while a pseudo-DMA access is waiting, and drops it once the DMA-acknowledge pulse has begun.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RAM  = 2'd1,
    RG_EXP  = 2'd2,
    RG_SCSI = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DELAY    = 3'd1,
    ST_DRQ_WAIT = 3'd2,
    ST_ACKED    = 3'd3,
    ST_FAULT    = 3'd4,
    ST_HOLD     = 3'd5
  } state_e;

  // Priority: SCSI over expansion over memory.
  function automatic region_e pick_region(input logic ram, input logic exp,
                                          input logic scsi);
    if (scsi)     return RG_SCSI;
    else if (exp) return RG_EXP;
    else if (ram) return RG_RAM;
    else          return RG_NONE;
  endfunction

  // Regions guarded by the stall watchdog.
  function automatic logic watched(input region_e r);
    return (r == RG_EXP) || (r == RG_SCSI);
  endfunction

  // Counter width that can hold values 0 .. limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/bct_cycle_timer.sv
module bct_cycle_timer
  import bct_pkg::*;
#(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic hit
);
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  // hit fires on the LIMIT-th running edge after a clear
  assign hit = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (run && !hit)   cnt <= cnt + 1'b1;
  end

  // R10
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R10
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/bct_dack_pulse.sv
module bct_dack_pulse
  import bct_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned W = cnt_width(WIDTH);
  localparam logic [W-1:0] FIRST = W'(WIDTH - 1);

  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
    end else if (fire) begin
      active <= 1'b1;
      left   <= FIRST;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - 1'b1;
    end
  end

  generate
    if (WIDTH > 1) begin : g_wide
      // R5
      pulse_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> active);
    end
  endgenerate

endmodule

// File: rtl/bus_cycle_term.sv
module bus_cycle_term
  import bct_pkg::*;
#(
  parameter int unsigned ACK_DLY = 3,
  parameter int unsigned DACK_W  = 4,
  parameter int unsigned TMO_CYC = 4151808
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic sel_ram,
  input  logic sel_exp,
  input  logic sel_scsi,
  input  logic sel_pdma,
  input  logic drq,
  input  logic ext_ack_n,
  output logic dtack_oe,
  output logic berr_n,
  output logic dack_n,
  output logic scsi_cs_n
);

  state_e  state;
  region_e region_q;
  logic    pdma_q;
  logic    ack_q;
  logic    berr_n_q;
  logic    cs_n_q;
  logic    dack_act;

  // Named events shared by the logic and the assertions
  logic ev_start, ev_end, ev_dly_done, ev_tmo, ev_drq_take;
  logic dly_run, tmo_run;
  region_e region_in;

  assign region_in   = pick_region(sel_ram, sel_exp, sel_scsi);
  assign ev_start    = (state == ST_IDLE) && !as_n && !dack_act;
  assign ev_end      = (state != ST_IDLE) && as_n;
  assign dly_run     = (state == ST_DELAY) && !as_n;
  assign tmo_run     = (state != ST_IDLE) && (state != ST_FAULT) && !as_n
                       && watched(region_q);
  assign ev_drq_take = (state == ST_DRQ_WAIT) && !as_n && drq && !ev_tmo;

  bct_cycle_timer #(.LIMIT(ACK_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .run(dly_run),
    .hit(ev_dly_done)
  );

  bct_cycle_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .run(tmo_run),
    .hit(ev_tmo)
  );

  bct_dack_pulse #(.WIDTH(DACK_W)) u_dack (
    .clk(clk), .rst_n(rst_n), .fire(ev_drq_take), .active(dack_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      region_q <= RG_NONE;
      pdma_q   <= 1'b0;
      ack_q    <= 1'b0;
      berr_n_q <= 1'b1;
      cs_n_q   <= 1'b1;
    end else if (ev_end) begin
      state    <= ST_IDLE;
      ack_q    <= 1'b0;
      berr_n_q <= 1'b1;
      cs_n_q   <= 1'b1;
    end else if (ev_tmo) begin
      state    <= ST_FAULT;
      berr_n_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ev_start) begin
            region_q <= region_in;
            pdma_q   <= sel_pdma && (region_in == RG_SCSI);
            cs_n_q   <= (region_in != RG_SCSI);
            state    <= (region_in == RG_NONE) ? ST_HOLD : ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (ev_dly_done) begin
            if (pdma_q) begin
              cs_n_q <= 1'b1;
              state  <= ST_DRQ_WAIT;
            end else begin
              ack_q  <= 1'b1;
              state  <= ST_ACKED;
            end
          end
        end
        ST_DRQ_WAIT: begin
          if (ev_drq_take) begin
            ack_q <= 1'b1;
            state <= ST_ACKED;
          end
        end
        default: ;
      endcase
    end
  end

  assign dtack_oe  = ack_q & ext_ack_n;
  assign berr_n    = berr_n_q;
  assign dack_n    = ~dack_act;
  assign scsi_cs_n = cs_n_q;

  // R6
  dack_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dack_act && !cs_n_q));

  // R4
  drq_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRQ_WAIT) |-> (cs_n_q && !ack_q));

  // R5
  dack_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dack_act) |-> ack_q);

  // R9
  ram_no_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !watched(region_q)) |-> berr_n_q);

  // R10
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (!ack_q && berr_n_q && cs_n_q));

  // R11
  no_region_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !ack_q);

  // R2
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> ($past(state) == ST_DELAY || $past(state) == ST_DRQ_WAIT));

endmodule

// File: tb/bus_cycle_term_tb.sv
`timescale 1ns/100ps
module bus_cycle_term_tb;

  localparam int D = 3;
  localparam int W = 4;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, sel_ram = 1'b0, sel_exp = 1'b0, sel_scsi = 1'b0;
  logic sel_pdma = 1'b0, drq = 1'b0, ext_ack_n = 1'b1;
  logic dtack_oe, berr_n, dack_n, scsi_cs_n;

  bus_cycle_term #(.ACK_DLY(D), .DACK_W(W), .TMO_CYC(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .sel_ram(sel_ram),
    .sel_exp(sel_exp), .sel_scsi(sel_scsi), .sel_pdma(sel_pdma), .drq(drq),
    .ext_ack_n(ext_ack_n), .dtack_oe(dtack_oe), .berr_n(berr_n),
    .dack_n(dack_n), .scsi_cs_n(scsi_cs_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string req;
  } exp_t;
  exp_t sb[$];

  function automatic logic pick(int sig);
    case (sig)
      0: return dtack_oe;
      1: return berr_n;
      2: return dack_n;
      default: return scsi_cs_n;
    endcase
  endfunction

  function automatic string sname(int sig);
    case (sig)
      0: return "dtack_oe";
      1: return "berr_n";
      2: return "dack_n";
      default: return "scsi_cs_n";
    endcase
  endfunction

  task automatic expect_at(int at, int sig, logic val, string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compare due items away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].at == cyc) begin
          logic got;
          got = pick(sb[i].sig);
          checks++;
          if (got !== sb[i].val) begin
            errors++;
            $display("FAIL %s cycle %0d %s actual=%b expected=%b",
                     sb[i].req, cyc, sname(sb[i].sig), got, sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic wait_cyc(int c);
    while (cyc < c) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Drive strobe low with selects; returns the expected start edge index
  task automatic begin_access(logic r, logic x, logic s, logic p, output int st);
    as_n = 1'b0; sel_ram = r; sel_exp = x; sel_scsi = s; sel_pdma = p;
    st = cyc + 1;
  endtask

  // Raise strobe; returns the cycle in which outputs are released
  task automatic end_access(output int rel);
    as_n = 1'b1; sel_ram = 1'b0; sel_exp = 1'b0; sel_scsi = 1'b0;
    sel_pdma = 1'b0;
    rel = cyc + 1;
  endtask

  task automatic direct(logic got, logic want, string what);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", what, got, want);
    end
  endtask

  initial begin
    int s, r, e, s2;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    direct(dtack_oe, 1'b0, "R1 dtack_oe");
    direct(berr_n, 1'b1, "R1 berr_n");
    direct(dack_n, 1'b1, "R1 dack_n");
    direct(scsi_cs_n, 1'b1, "R1 scsi_cs_n");
    @(posedge clk); #1;
    rst_n = 1'b1;
    wait_cyc(cyc + 2);

    // R2: memory access
    begin_access(1, 0, 0, 0, s);
    expect_at(s + D - 1, 0, 1'b0, "R2");
    expect_at(s + D, 0, 1'b1, "R2");
    wait_cyc(s + D + 2);
    end_access(r);
    expect_at(r, 0, 1'b0, "R10");
    expect_at(r, 1, 1'b1, "R10");
    wait_cyc(r + 3);

    // R2: expansion access acknowledged by the block
    begin_access(0, 1, 0, 0, s);
    expect_at(s + D - 1, 0, 1'b0, "R2");
    expect_at(s + D, 0, 1'b1, "R2");
    wait_cyc(s + D + 1);
    end_access(r);
    expect_at(r, 0, 1'b0, "R10");
    wait_cyc(r + 3);

    // R3: plain SCSI register access
    begin_access(0, 0, 1, 0, s);
    expect_at(s - 1, 3, 1'b1, "R3");
    expect_at(s, 3, 1'b0, "R3");
    expect_at(s + D, 0, 1'b1, "R2");
    expect_at(s + D + 2, 3, 1'b0, "R3");
    wait_cyc(s + D + 3);
    end_access(r);
    expect_at(r, 3, 1'b1, "R3");
    expect_at(r, 0, 1'b0, "R10");
    wait_cyc(r + 3);

    // R7: expansion card claims the acknowledge
    ext_ack_n = 1'b0;
    begin_access(0, 1, 0, 0, s);
    expect_at(s + D, 0, 1'b0, "R7");
    expect_at(s + D + 1, 0, 1'b0, "R7");
    expect_at(s + D + 2, 0, 1'b1, "R7");
    wait_cyc(s + D + 2);
    ext_ack_n = 1'b1;
    wait_cyc(s + D + 3);
    end_access(r);
    wait_cyc(r + 3);

    // R4/R5/R6: pseudo-DMA access with late DRQ, then blocked restart
    begin_access(0, 0, 1, 1, s);
    expect_at(s, 3, 1'b0, "R4");
    expect_at(s + D - 1, 3, 1'b0, "R4");
    expect_at(s + D, 3, 1'b1, "R4");
    expect_at(s + D, 0, 1'b0, "R4");
    expect_at(s + D + 3, 0, 1'b0, "R4");
    expect_at(s + D + 3, 2, 1'b1, "R5");
    e = s + D + 4;
    expect_at(e, 0, 1'b1, "R5");
    expect_at(e, 2, 1'b0, "R5");
    expect_at(e, 3, 1'b1, "R6");
    wait_cyc(s + D + 3);
    drq = 1'b1;
    wait_cyc(e);
    drq = 1'b0;
    wait_cyc(e + 1);
    end_access(r);
    expect_at(r, 0, 1'b0, "R10");
    expect_at(r, 2, 1'b0, "R5");
    expect_at(e + W - 1, 2, 1'b0, "R5");
    expect_at(e + W, 2, 1'b1, "R5");
    wait_cyc(e + 2);
    begin_access(0, 0, 1, 0, s2);
    s2 = e + W + 1;
    expect_at(e + W - 1, 3, 1'b1, "R6");
    expect_at(e + W, 3, 1'b1, "R6");
    expect_at(s2, 3, 1'b0, "R6");
    expect_at(s2 + D - 1, 0, 1'b0, "R2");
    expect_at(s2 + D, 0, 1'b1, "R2");
    wait_cyc(s2 + D + 1);
    end_access(r);
    wait_cyc(r + 3);

    // R8: stalled expansion access times out
    ext_ack_n = 1'b0;
    begin_access(0, 1, 0, 0, s);
    expect_at(s + T - 1, 1, 1'b1, "R8");
    expect_at(s + T, 1, 1'b0, "R8");
    expect_at(s + T + 2, 1, 1'b0, "R8");
    wait_cyc(s + T + 3);
    end_access(r);
    expect_at(r, 1, 1'b1, "R10");
    wait_cyc(r + 2);

    // R10: watchdog count restarts for the next access
    begin_access(0, 1, 0, 0, s);
    expect_at(s + T - 1, 1, 1'b1, "R10");
    expect_at(s + T, 1, 1'b0, "R10");
    wait_cyc(s + T + 1);
    end_access(r);
    wait_cyc(r + 2);
    ext_ack_n = 1'b1;

    // R8: pseudo-DMA access whose DRQ never comes
    begin_access(0, 0, 1, 1, s);
    expect_at(s + T - 1, 1, 1'b1, "R8");
    expect_at(s + T, 1, 1'b0, "R8");
    expect_at(s + T, 0, 1'b0, "R4");
    expect_at(s + T, 2, 1'b1, "R6");
    wait_cyc(s + T + 1);
    end_access(r);
    expect_at(r, 1, 1'b1, "R10");
    wait_cyc(r + 2);

    // R9: memory access held past the watchdog limit
    begin_access(1, 0, 0, 0, s);
    expect_at(s + T, 1, 1'b1, "R9");
    expect_at(s + T + 15, 1, 1'b1, "R9");
    wait_cyc(s + T + 16);
    end_access(r);
    wait_cyc(r + 2);

    // R11: access with no region selected
    begin_access(0, 0, 0, 0, s);
    expect_at(s + D, 0, 1'b0, "R11");
    expect_at(s + D + 5, 0, 1'b0, "R11");
    expect_at(s + T + 2, 1, 1'b1, "R9");
    wait_cyc(s + T + 3);
    end_access(r);
    wait_cyc(r + 4);

    if (sb.size() != 0) begin
      errors += sb.size();
      checks += sb.size();
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=cycle %0d expected=finished", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule